// File: doc/BRIEF.md
# Interrupt Routing Controller Register Window

This block is the register front end of an I/O interrupt routing controller. Software reaches it through two byte offsets on a single-cycle register port. One is an 8-bit select register. The other is a 32-bit data window. The select value picks what the window reaches: the controller identification register, a read-only version word, an arbitration register that mirrors the identification value, or one 32-bit half of a 64-bit per-pin routing entry.

The block stores the routing table and presents every entry at all times on a flat output bus for the delivery logic. When a write toggles a pin's mask bit, the block pulses that pin's mask-change output. When a low-half write leaves an entry level-triggered while the pin's registered request bit is pending, it pulses a service request. The delivery logic can set an entry's remote-IRR bit through a per-pin strobe. A low-half write clears that bit.

Entry layout: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote IRR [14], trigger mode [15] (1 = level), mask [16], destination [63:56]. The remaining bits are stored but have no function.

Top module: `irq_route_regwin`

## Requirements
- R1: A write at byte offset 0x00 stores bus_wdata[7:0] as the select value. A read at offset 0x00 returns it zero-extended.
- R2: With select 0x01, a window read at offset 0x10 returns (pin count - 1) in bits 23:16 and the version code in bits 7:0. The default is 0x00170011. Window writes with this select change nothing.
- R3: With select 0x00, a window write stores bus_wdata[27:24] as the identifier, and a window read returns it in bits 27:24 with all other bits zero. With select 0x02, a read returns the same word and a write is ignored.
- R4: A select of 0x10 or above addresses entry (select - 0x10) >> 1. An odd select reaches bits 63:32 and an even select reaches bits 31:0. The other half and the other entries are kept. The entry is visible on ent_flat at bits [64*pin +: 64].
- R5: A low-half write forces the entry's remote-IRR bit (bit 14) to 0. A high-half write leaves it unchanged. A pulse on rirr_set[pin] sets it to 1 at the next edge.
- R6: When the computed index is 24 or more, a window write changes no entry and raises no pulse, and a window read returns 0. Index 23 (selects 0x3E and 0x3F) works normally.
- R7: mask_chg[pin] is high for exactly the one cycle after a write edge, and only when that write flipped the pin's mask bit (bit 16).
- R8: After reset the select, identifier and pending-request registers are 0, every entry reads 0x0000000000010000 (only the mask set), and no pulse is active.
- R9: A read at any offset other than 0x00 and 0x10 returns 0. A write there changes no state.
- R10: svc_req[pin] is high for the one cycle after a low-half write that leaves bit 15 at 1 while the pin's pending request was set. pend_in is registered once before use. An edge-triggered write, or one with no pending request, raises no request.
- R11: Selects 0x03 through 0x0F read 0 through the window, and writes with them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| rirr_set | input | 24 | Per-pin strobe that sets remote IRR |
| pend_in | input | 24 | Per-pin pending request level from the pin logic |
| ent_flat | output | 1536 | All routing entries, 64 bits per pin |
| mask_chg | output | 24 | One-cycle pulse per pin on a mask toggle |
| svc_req | output | 24 | One-cycle pulse per pin requesting delivery |

## Verification
The service request is the hardest case to reach. It needs three things at the same edge: a low-half write, a level trigger in the written data, and a pending bit already registered from pend_in. The bench raises pend_in for pin 5 a cycle ahead and then rewrites the entry's low half. It then repeats the write with an edge trigger, and once more with the request dropped, to show that neither variant raises a pulse. Setting remote IRR through its strobe and then writing each half in turn separates the clearing by the low half from the high half, which leaves the bit alone.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam int          SELW     = 8;
    localparam int          DW       = 32;
    localparam int          EW       = 64;
    localparam int          IDXW     = SELW - 1;
    localparam logic [7:0]  OFS_SEL  = 8'h00;
    localparam logic [7:0]  OFS_WIN  = 8'h10;
    localparam logic [7:0]  SEL_ID   = 8'h00;
    localparam logic [7:0]  SEL_VER  = 8'h01;
    localparam logic [7:0]  SEL_ARB  = 8'h02;
    localparam logic [7:0]  SEL_ENT0 = 8'h10;

    typedef enum logic [2:0] {
        RK_ID,
        RK_VER,
        RK_ARB,
        RK_ENT,
        RK_NONE
    } rkind_e;

    typedef struct packed {
        rkind_e            kind;
        logic [IDXW-1:0]   idx;
        logic              hi;
    } sel_dec_t;

    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        trig;
        logic        rirr;
        logic        pol;
        logic        dstat;
        logic        dmode;
        logic [2:0]  dlv;
        logic [7:0]  vec;
    } rte_t;

    localparam rte_t RTE_RESET = '{mask: 1'b1, default: '0};

    function automatic sel_dec_t decode_sel(input logic [SELW-1:0] s, input int npins);
        sel_dec_t        d;
        logic [SELW-1:0] off;
        off    = s - SEL_ENT0;
        d.idx  = off[SELW-1:1];
        d.hi   = s[0];
        d.kind = RK_NONE;
        if (s == SEL_ID)
            d.kind = RK_ID;
        else if (s == SEL_VER)
            d.kind = RK_VER;
        else if (s == SEL_ARB)
            d.kind = RK_ARB;
        else if (s >= SEL_ENT0 && int'(d.idx) < npins)
            d.kind = RK_ENT;
        return d;
    endfunction

endpackage

// File: rtl/irw_sel_decode.sv
module irw_sel_decode
    import irw_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic [SELW-1:0] sel,
    output rkind_e          kind,
    output logic            hi,
    output logic [NPINS-1:0] ent_hit
);
    sel_dec_t dec;

    always_comb dec = decode_sel(sel, NPINS);

    assign kind = dec.kind;
    assign hi   = dec.hi;

    for (genvar i = 0; i < NPINS; i++) begin : g_hit
        assign ent_hit[i] = (dec.kind == RK_ENT) && (dec.idx == IDXW'(i));
    end
endmodule

// File: rtl/irw_entry.sv
module irw_entry
    import irw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          rirr_set,
    input  logic          pend,
    output rte_t          ent,
    output logic          mask_chg,
    output logic          svc
);
    rte_t nxt;

    always_comb begin
        nxt = ent;
        if (wr_hi)
            nxt[EW-1:DW] = wdata;
        if (rirr_set)
            nxt.rirr = 1'b1;
        if (wr_lo) begin
            nxt[DW-1:0] = wdata;
            nxt.rirr    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent      <= RTE_RESET;
            mask_chg <= 1'b0;
            svc      <= 1'b0;
        end else begin
            ent      <= nxt;
            mask_chg <= nxt.mask ^ ent.mask;
            svc      <= wr_lo & nxt.trig & pend;
        end
    end
endmodule

// File: rtl/irw_rd_mux.sv
module irw_rd_mux
    import irw_pkg::*;
#(
    parameter int         NPINS    = 24,
    parameter logic [7:0] VER_CODE = 8'h11
) (
    input  logic [7:0]       addr,
    input  logic [SELW-1:0]  sel,
    input  rkind_e           kind,
    input  logic             hi,
    input  logic [NPINS-1:0] ent_hit,
    input  logic [3:0]       id,
    input  logic [NPINS*EW-1:0] ent_flat,
    output logic [DW-1:0]    rdata
);
    localparam logic [7:0] MAXPIN = 8'(NPINS - 1);

    logic [EW-1:0] ent_sel;
    logic [DW-1:0] win;

    always_comb begin
        ent_sel = '0;
        for (int i = 0; i < NPINS; i++)
            if (ent_hit[i])
                ent_sel = ent_flat[i*EW +: EW];
    end

    always_comb begin
        unique case (kind)
            RK_ID, RK_ARB: win = {4'h0, id, 24'h0};
            RK_VER:        win = {8'h00, MAXPIN, 8'h00, VER_CODE};
            RK_ENT:        win = hi ? ent_sel[EW-1:DW] : ent_sel[DW-1:0];
            default:       win = '0;
        endcase
    end

    always_comb begin
        if (addr == OFS_SEL)
            rdata = {{(DW-SELW){1'b0}}, sel};
        else if (addr == OFS_WIN)
            rdata = win;
        else
            rdata = '0;
    end
endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
    import irw_pkg::*;
#(
    parameter int         NPINS    = 24,
    parameter logic [7:0] VER_CODE = 8'h11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NPINS-1:0]    rirr_set,
    input  logic [NPINS-1:0]    pend_in,
    output logic [NPINS*64-1:0] ent_flat,
    output logic [NPINS-1:0]    mask_chg,
    output logic [NPINS-1:0]    svc_req
);
    logic [SELW-1:0]  sel_q;
    logic [3:0]       id_q;
    logic [NPINS-1:0] pend_q;
    rkind_e           kind;
    logic             hi;
    logic [NPINS-1:0] ent_hit;
    logic             sel_wr;
    logic             win_wr;
    rte_t             ent_q [NPINS];

    assign sel_wr = bus_we && (bus_addr == OFS_SEL);
    assign win_wr = bus_we && (bus_addr == OFS_WIN);

    irw_sel_decode #(.NPINS(NPINS)) u_dec (
        .sel     (sel_q),
        .kind    (kind),
        .hi      (hi),
        .ent_hit (ent_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            id_q   <= '0;
            pend_q <= '0;
        end else begin
            pend_q <= pend_in;
            if (sel_wr)
                sel_q <= bus_wdata[SELW-1:0];
            if (win_wr && kind == RK_ID)
                id_q <= bus_wdata[27:24];
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_ent
        irw_entry u_ent (
            .clk      (clk),
            .rst      (rst),
            .wr_lo    (win_wr && ent_hit[i] && !hi),
            .wr_hi    (win_wr && ent_hit[i] && hi),
            .wdata    (bus_wdata),
            .rirr_set (rirr_set[i]),
            .pend     (pend_q[i]),
            .ent      (ent_q[i]),
            .mask_chg (mask_chg[i]),
            .svc      (svc_req[i])
        );
        assign ent_flat[i*EW +: EW] = ent_q[i];
    end

    irw_rd_mux #(.NPINS(NPINS), .VER_CODE(VER_CODE)) u_rd (
        .addr     (bus_addr),
        .sel      (sel_q),
        .kind     (kind),
        .hi       (hi),
        .ent_hit  (ent_hit),
        .id       (id_q),
        .ent_flat (ent_flat),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/irw_chk.sv
module irw_chk
    import irw_pkg::*;
#(
    parameter int NPINS = 24
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          bus_addr,
    input logic                bus_we,
    input logic [7:0]          wdata_lo,
    input logic [31:0]         bus_rdata,
    input logic [7:0]          sel_q,
    input logic [NPINS*64-1:0] ent_flat,
    input logic [NPINS-1:0]    mask_chg,
    input logic [NPINS-1:0]    svc_req
);
    logic [NPINS-1:0] mask_vec;
    logic [NPINS-1:0] rirr_vec;
    logic [7:0]       off;
    logic [6:0]       idx;
    logic             win_wr;
    logic             in_tab;
    logic             lo_wr_d;
    logic [6:0]       idx_d;

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            mask_vec[i] = ent_flat[i*64 + 16];
            rirr_vec[i] = ent_flat[i*64 + 14];
        end
    end

    assign off    = sel_q - 8'h10;
    assign idx    = off[7:1];
    assign win_wr = bus_we && (bus_addr == OFS_WIN);
    assign in_tab = (sel_q >= 8'h10) && (int'(idx) < NPINS);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_wr_d <= 1'b0;
            idx_d   <= '0;
        end else begin
            lo_wr_d <= win_wr && in_tab && !sel_q[0];
            idx_d   <= idx;
        end
    end

    // R1
    sel_store_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_SEL) |=> (sel_q == $past(wdata_lo)));

    // R9
    other_ofs_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != OFS_SEL && bus_addr != OFS_WIN) |-> (bus_rdata == 32'h0));

    // R7
    mask_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mask_chg == (mask_vec ^ $past(mask_vec)));

    // R5
    rirr_lo_clr_chk: assert property (@(posedge clk) disable iff (rst)
        lo_wr_d |-> (rirr_vec[idx_d[4:0]] == 1'b0));

    // R10
    svc_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|svc_req) |-> $past(win_wr));

    // R6
    oor_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (win_wr && sel_q >= 8'h10 && int'(idx) >= NPINS) |=> $stable(ent_flat));

    // R8
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (sel_q == 8'h0 && (&mask_vec) && mask_chg == '0 && svc_req == '0));
endmodule

bind irq_route_regwin irw_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .wdata_lo  (bus_wdata[7:0]),
    .bus_rdata (bus_rdata),
    .sel_q     (sel_q),
    .ent_flat  (ent_flat),
    .mask_chg  (mask_chg),
    .svc_req   (svc_req)
);

// File: tb/irq_route_regwin_tb.sv
`timescale 1ns/1ps
module irq_route_regwin_tb;
    localparam int NP = 24;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     bus_addr = '0;
    logic           bus_we = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NP-1:0]  rirr_set = '0;
    logic [NP-1:0]  pend_in = '0;
    logic [NP*64-1:0] ent_flat;
    logic [NP-1:0]  mask_chg;
    logic [NP-1:0]  svc_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        int          idx;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    irq_route_regwin u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rirr_set(rirr_set),
        .pend_in(pend_in), .ent_flat(ent_flat), .mask_chg(mask_chg),
        .svc_req(svc_req)
    );

    task automatic op(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        bus_we    = w;
        bus_addr  = a;
        bus_wdata = d;
        rirr_set  = '0;
    endtask

    task automatic want(input int k, input int i, input logic [63:0] e, input string tag);
        item_t it;
        it.kind = k;
        it.idx  = i;
        it.exp  = e;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic wsel(input logic [7:0] s);
        op(1'b1, 8'h00, {24'h0, s});
    endtask

    task automatic wwin(input logic [31:0] d);
        op(1'b1, 8'h10, d);
    endtask

    task automatic rwin(input logic [31:0] e, input string tag);
        op(1'b0, 8'h10, 32'h0);
        want(0, 0, {32'h0, e}, tag);
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [63:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = {32'h0, bus_rdata};
                1: act = {40'h0, mask_chg};
                2: act = {40'h0, svc_req};
                default: act = ent_flat[it.idx*64 +: 64];
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R8 reset state
        op(1'b0, 8'h00, 0);
        want(0, 0, 64'h0, "R8 select after reset");
        want(1, 0, 64'h0, "R8 no mask pulse");
        want(2, 0, 64'h0, "R8 no service pulse");
        want(3, 0, 64'h10000, "R8 pin0 entry");
        want(3, 23, 64'h10000, "R8 pin23 entry");
        rwin(32'h0, "R8 identifier zero");

        // R1 select store and truncation
        op(1'b1, 8'h00, 32'h000001A5);
        op(1'b0, 8'h00, 0);
        want(0, 0, 64'hA5, "R1 select readback");

        // R2 version
        wsel(8'h01);
        rwin(32'h00170011, "R2 version word");
        wwin(32'hFFFFFFFF);
        rwin(32'h00170011, "R2 version write ignored");

        // R3 identifier and arbitration
        wsel(8'h00);
        wwin(32'h5ABCDEF0);
        rwin(32'h0A000000, "R3 identifier");
        wsel(8'h02);
        rwin(32'h0A000000, "R3 arbitration mirror");
        wwin(32'h03000000);
        rwin(32'h0A000000, "R3 arbitration write ignored");
        wsel(8'h00);
        rwin(32'h0A000000, "R3 identifier kept");

        // R4 and R7 entry halves, mask toggle
        wsel(8'h1A);
        wwin(32'h0000A031);
        rwin(32'h0000A031, "R4 low half pin5");
        want(1, 0, 64'h20, "R7 mask pulse pin5");
        wsel(8'h1B);
        wwin(32'hC3000000);
        rwin(32'hC3000000, "R4 high half pin5");
        want(3, 5, 64'hC3000000_0000A031, "R4 pin5 entry");
        want(3, 4, 64'h10000, "R4 pin4 untouched");
        want(1, 0, 64'h0, "R7 high write no pulse");

        // R5 remote IRR
        op(1'b0, 8'h00, 0);
        rirr_set[5] = 1'b1;
        wsel(8'h1A);
        rwin(32'h0000E031, "R5 remote IRR set");
        wsel(8'h1B);
        wwin(32'hC4000000);
        wsel(8'h1A);
        rwin(32'h0000E031, "R5 high write keeps remote IRR");
        wwin(32'h0000A031);
        rwin(32'h0000A031, "R5 low write clears remote IRR");
        want(1, 0, 64'h0, "R7 no toggle no pulse");

        // R10 service request
        pend_in[5] = 1'b1;
        op(1'b0, 8'h00, 0);
        wsel(8'h1A);
        wwin(32'h0000A031);
        op(1'b0, 8'h00, 0);
        want(2, 0, 64'h20, "R10 level pending request");
        wsel(8'h1A);
        wwin(32'h00002031);
        op(1'b0, 8'h00, 0);
        want(2, 0, 64'h0, "R10 edge trigger no request");
        pend_in[5] = 1'b0;
        op(1'b0, 8'h00, 0);
        wsel(8'h1A);
        wwin(32'h0000A031);
        op(1'b0, 8'h00, 0);
        want(2, 0, 64'h0, "R10 no pending no request");

        // R6 boundary and out of range
        wsel(8'h3F);
        wwin(32'hAB000000);
        rwin(32'hAB000000, "R6 last pin high half");
        want(3, 23, 64'hAB000000_00010000, "R6 last pin entry");
        wsel(8'h3E);
        rwin(32'h00010000, "R6 last pin low half");
        wsel(8'h40);
        wwin(32'hFFFFFFFF);
        rwin(32'h0, "R6 out of range read");
        want(1, 0, 64'h0, "R6 out of range no pulse");
        want(3, 0, 64'h10000, "R6 pin0 untouched");
        wsel(8'h41);
        rwin(32'h0, "R6 out of range high read");

        // R9 other offsets
        wsel(8'h1A);
        op(1'b0, 8'h04, 0);
        want(0, 0, 64'h0, "R9 offset 04 reads zero");
        op(1'b0, 8'hF0, 0);
        want(0, 0, 64'h0, "R9 offset F0 reads zero");
        op(1'b1, 8'h08, 32'h00000077);
        op(1'b0, 8'h00, 0);
        want(0, 0, 64'h1A, "R9 write elsewhere keeps select");
        rwin(32'h0000A031, "R9 write elsewhere keeps entry");

        // R11 unused selects
        wsel(8'h05);
        rwin(32'h0, "R11 select 05 reads zero");
        wwin(32'hFFFFFFFF);
        wsel(8'h0F);
        rwin(32'h0, "R11 select 0F reads zero");
        wsel(8'h00);
        rwin(32'h0A000000, "R11 identifier kept");
        want(3, 0, 64'h10000, "R11 pin0 kept");

        op(1'b0, 8'h00, 0);
        op(1'b0, 8'h00, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule